// File: doc/BRIEF.md
# Memory Error Capture and Reporting

This block sits next to a memory controller and keeps a log of memory errors for software to read. Every memory access presents its address with a valid strobe. The error checker flags each access as clean, single-bit-error or double-bit-error, and supplies a syndrome. While nothing is logged, a shadow address register follows every valid access. The first access that carries an error freezes that register and records the error kind and syndrome in a status register. The status bits are low-true, so a bit that reads 0 means its condition is present.

Software reads three 16-bit registers over a simple register bus, at word addresses 177024 (error address), 177025 (error status) and 177026 (control), all octal. Any write to the status register clears the log and re-arms capture. When an error is logged and bit 0 of the control register is set, the block raises a request for one cycle. That request is merged into an interrupt-pending word by OR-ing a one into bit 15. The other bits of the word are left as they were.

Top module: `memerr_log`

## Requirements
- R1: After reset the status register reads 16'hFFFF, the control register reads 0, `irq_o` is low and `pend_o` equals `pend_i`.
- R2: While no error is logged, every access with `acc_valid` high loads its address into the error-address register (177024 octal, zero-extended), readable in the cycle after the access.
- R3: The first valid access that has `err_single` or `err_double` high loads its address into the error-address register and marks the log as full.
- R4: A logged status word is laid out as follows. Bit 0 is 0 for a single-bit error. Bit 1 is 0 for a double-bit error. Bits 7:2 hold the bitwise inverse of the syndrome. Bits 15:8 read 1.
- R5: While the log is full, later accesses and later errors change neither the error-address register nor the status register.
- R6: A write of any data to 177025 octal sets the status register to 16'hFFFF and re-arms capture. An access in the same cycle as the write loads its address.
- R7: If an error and a status write fall in the same cycle, the write wins. The error is not logged and raises no request. An error in the following cycle is logged.
- R8: An access with both error flags high is logged as a double-bit error only: status bits 1:0 read 2'b01.
- R9: The control register at 177026 octal stores and returns all 16 written bits. Its bit 0 enables the interrupt request. With bit 0 at 0, errors are still logged but `irq_o` stays low.
- R10: When an error is logged with requests enabled, `irq_o` is high for exactly the one cycle after the access. During that cycle `pend_o` is `pend_i` with bit 15 (value 16'h8000) set. In every other cycle `pend_o` equals `pend_i`.
- R11: Error flags that arrive with `acc_valid` low are ignored and do not change either register.
- R12: A read at any other bus address returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | A memory access is taking place this cycle |
| acc_addr | input | ADDR_W | Address of the access |
| err_single | input | 1 | Checker reports a single-bit error on this access |
| err_double | input | 1 | Checker reports a double-bit error on this access |
| err_syndrome | input | 6 | Checker syndrome for this access |
| rb_addr | input | 16 | Register bus word address |
| rb_wr | input | 1 | Register bus write strobe |
| rb_wdata | input | 16 | Register bus write data |
| rb_rdata | output | 16 | Register bus read data (combinational from rb_addr) |
| pend_i | input | 16 | Incoming interrupt-pending word |
| pend_o | output | 16 | Pending word with the error bit OR-ed in |
| irq_o | output | 1 | One-cycle error interrupt request |

## Verification
The bench builds the block with its default parameters: a 16-bit access address, a 6-bit syndrome and the request placed at bit 15. These values let the bench write full-width addresses and all-ones and all-zeros syndromes, and check the exact status words that come out. At this width the inverted syndrome fills bits 7:2 of the status word completely, so a misplaced or non-inverted field shows up directly in the read value.

// File: rtl/memerr_pkg.sv
package memerr_pkg;

  localparam int SYN_W  = 6;
  localparam int WORD_W = 16;

  // Low-true status word: double wins over single when both are flagged.
  function automatic logic [WORD_W-1:0] status_word(input logic sb,
                                                    input logic db,
                                                    input logic [SYN_W-1:0] syn);
    logic [WORD_W-1:0] w;
    w = '1;
    w[0] = ~(sb & ~db);
    w[1] = ~db;
    w[2 +: SYN_W] = ~syn;
    return w;
  endfunction

  // OR the request into one bit of the pending word, keep the rest.
  function automatic logic [WORD_W-1:0] merge_pend(input logic [WORD_W-1:0] word,
                                                   input int unsigned bitn,
                                                   input logic fire);
    logic [WORD_W-1:0] m;
    m = '0;
    m[bitn] = fire;
    return word | m;
  endfunction

endpackage

// File: rtl/memerr_capture.sv
module memerr_capture
  import memerr_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_valid,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic              err_single,
  input  logic              err_double,
  input  logic [SYN_W-1:0]  err_syndrome,
  input  logic              clr,
  output logic [ADDR_W-1:0] addr_q,
  output logic [WORD_W-1:0] stat_q,
  output logic              log_now
);

  logic full_q;
  logic err_seen;
  logic track;

  assign err_seen = acc_valid & (err_single | err_double);
  // A clearing write wins over a same-cycle error.
  assign log_now  = err_seen & ~full_q & ~clr;
  assign track    = acc_valid & (~full_q | clr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      addr_q <= '0;
      stat_q <= '1;
    end else begin
      if (track) addr_q <= acc_addr;
      if (clr) begin
        full_q <= 1'b0;
        stat_q <= '1;
      end else if (log_now) begin
        full_q <= 1'b1;
        stat_q <= status_word(err_single, err_double, err_syndrome);
      end
    end
  end

  // R2: address follows accesses while nothing is logged
  assert_addr_track_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !full_q) |=> (addr_q == $past(acc_addr)));

  // R5: a full log freezes address and status
  assert_addr_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (full_q && !clr) |=> $stable(addr_q));
  assert_stat_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (full_q && !clr) |=> $stable(stat_q));

  // R6: a status write leaves the cleared pattern and an empty log
  assert_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (stat_q == '1 && !full_q));

  // R11: flags without a valid access change nothing
  assert_ignore_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!acc_valid && !clr) |=> ($stable(stat_q) && $stable(addr_q)));

  // R8: a logged word never shows both kinds at once
  assert_one_kind_R8: assert property (@(posedge clk) disable iff (!rst_n)
    log_now |=> (stat_q[1:0] != 2'b00));

endmodule

// File: rtl/memerr_regs.sv
module memerr_regs
  import memerr_pkg::*;
#(
  parameter int          ADDR_W   = 16,
  parameter int unsigned IRQ_BIT  = 15,
  parameter logic [15:0] LOC_ADDR = 16'o177024,
  parameter logic [15:0] LOC_STAT = 16'o177025,
  parameter logic [15:0] LOC_CTRL = 16'o177026
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [15:0]       rb_addr,
  input  logic              rb_wr,
  input  logic [WORD_W-1:0] rb_wdata,
  output logic [WORD_W-1:0] rb_rdata,
  input  logic [ADDR_W-1:0] addr_val,
  input  logic [WORD_W-1:0] stat_val,
  input  logic              log_now,
  output logic              stat_clr,
  input  logic [WORD_W-1:0] pend_i,
  output logic [WORD_W-1:0] pend_o,
  output logic              irq_o
);

  logic [WORD_W-1:0] ctrl_q;
  logic              ctrl_wr;
  logic              irq_q;

  assign stat_clr = rb_wr && (rb_addr == LOC_STAT);
  assign ctrl_wr  = rb_wr && (rb_addr == LOC_CTRL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      if (ctrl_wr) ctrl_q <= rb_wdata;
      irq_q <= log_now & ctrl_q[0];
    end
  end

  always_comb begin
    rb_rdata = '0;
    if (rb_addr == LOC_ADDR)      rb_rdata[ADDR_W-1:0] = addr_val;
    else if (rb_addr == LOC_STAT) rb_rdata = stat_val;
    else if (rb_addr == LOC_CTRL) rb_rdata = ctrl_q;
  end

  assign irq_o  = irq_q;
  assign pend_o = merge_pend(pend_i, IRQ_BIT, irq_q);

  // R10: the merge only ever sets bits, never clears one
  always_comb begin
    assert_pend_keep_R10: assert ((pend_o & pend_i) == pend_i);
  end

  // R10: request lasts a single cycle
  assert_irq_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |=> !irq_q);

  // R9: no request while the enable bit is clear
  assert_irq_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_q[0] |=> !irq_q);

endmodule

// File: rtl/memerr_log.sv
module memerr_log
  import memerr_pkg::*;
#(
  parameter int          ADDR_W   = 16,
  parameter int unsigned IRQ_BIT  = 15,
  parameter logic [15:0] LOC_ADDR = 16'o177024,
  parameter logic [15:0] LOC_STAT = 16'o177025,
  parameter logic [15:0] LOC_CTRL = 16'o177026
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_valid,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic              err_single,
  input  logic              err_double,
  input  logic [5:0]        err_syndrome,
  input  logic [15:0]       rb_addr,
  input  logic              rb_wr,
  input  logic [15:0]       rb_wdata,
  output logic [15:0]       rb_rdata,
  input  logic [15:0]       pend_i,
  output logic [15:0]       pend_o,
  output logic              irq_o
);

  logic [ADDR_W-1:0] addr_val;
  logic [WORD_W-1:0] stat_val;
  logic              log_now;
  logic              stat_clr;

  memerr_capture #(.ADDR_W(ADDR_W)) u_cap (
    .clk          (clk),
    .rst_n        (rst_n),
    .acc_valid    (acc_valid),
    .acc_addr     (acc_addr),
    .err_single   (err_single),
    .err_double   (err_double),
    .err_syndrome (err_syndrome),
    .clr          (stat_clr),
    .addr_q       (addr_val),
    .stat_q       (stat_val),
    .log_now      (log_now)
  );

  memerr_regs #(
    .ADDR_W   (ADDR_W),
    .IRQ_BIT  (IRQ_BIT),
    .LOC_ADDR (LOC_ADDR),
    .LOC_STAT (LOC_STAT),
    .LOC_CTRL (LOC_CTRL)
  ) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .rb_addr  (rb_addr),
    .rb_wr    (rb_wr),
    .rb_wdata (rb_wdata),
    .rb_rdata (rb_rdata),
    .addr_val (addr_val),
    .stat_val (stat_val),
    .log_now  (log_now),
    .stat_clr (stat_clr),
    .pend_i   (pend_i),
    .pend_o   (pend_o),
    .irq_o    (irq_o)
  );

endmodule

// File: tb/tb_memerr_log.sv
`timescale 1ns/1ps
module tb_memerr_log;

  localparam logic [15:0] A_ADDR = 16'o177024;
  localparam logic [15:0] A_STAT = 16'o177025;
  localparam logic [15:0] A_CTRL = 16'o177026;
  localparam logic [15:0] PEND   = 16'h0003;

  typedef struct packed {
    logic [3:0]  req;
    logic        av;
    logic [15:0] a;
    logic        s;
    logic        d;
    logic [5:0]  syn;
    logic        sw;
    logic [15:0] ea;
    logic [15:0] es;
    logic        ei;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VT [NV] = '{
    '{4'd2,  1'b1, 16'h0100, 1'b0, 1'b0, 6'h00, 1'b0, 16'h0100, 16'hFFFF, 1'b0}, // R2
    '{4'd2,  1'b1, 16'h0222, 1'b0, 1'b0, 6'h00, 1'b0, 16'h0222, 16'hFFFF, 1'b0}, // R2
    '{4'd11, 1'b0, 16'h0333, 1'b1, 1'b0, 6'h12, 1'b0, 16'h0222, 16'hFFFF, 1'b0}, // R11
    '{4'd4,  1'b1, 16'h0444, 1'b1, 1'b0, 6'h15, 1'b0, 16'h0444, 16'hFFAA, 1'b1}, // R3 R4 R10
    '{4'd5,  1'b1, 16'h0555, 1'b0, 1'b1, 6'h03, 1'b0, 16'h0444, 16'hFFAA, 1'b0}, // R5
    '{4'd6,  1'b0, 16'h0000, 1'b0, 1'b0, 6'h00, 1'b1, 16'h0444, 16'hFFFF, 1'b0}, // R6
    '{4'd4,  1'b1, 16'h0666, 1'b0, 1'b1, 6'h3F, 1'b0, 16'h0666, 16'hFF01, 1'b1}, // R4 double
    '{4'd7,  1'b1, 16'h0777, 1'b1, 1'b0, 6'h01, 1'b1, 16'h0777, 16'hFFFF, 1'b0}, // R7
    '{4'd8,  1'b1, 16'h0888, 1'b1, 1'b1, 6'h00, 1'b0, 16'h0888, 16'hFFFD, 1'b1}  // R8, R7 next cycle
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        acc_valid = 1'b0;
  logic [15:0] acc_addr = '0;
  logic        err_single = 1'b0;
  logic        err_double = 1'b0;
  logic [5:0]  err_syndrome = '0;
  logic [15:0] rb_addr = '0;
  logic        rb_wr = 1'b0;
  logic [15:0] rb_wdata = '0;
  logic [15:0] rb_rdata;
  logic [15:0] pend_i = PEND;
  logic [15:0] pend_o;
  logic        irq_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  memerr_log dut (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_addr(acc_addr),
    .err_single(err_single), .err_double(err_double), .err_syndrome(err_syndrome),
    .rb_addr(rb_addr), .rb_wr(rb_wr), .rb_wdata(rb_wdata), .rb_rdata(rb_rdata),
    .pend_i(pend_i), .pend_o(pend_o), .irq_o(irq_o)
  );

  task automatic chk(input string r, input string what,
                     input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", r, what, act, exp);
    end
  endtask

  task automatic rd(input logic [15:0] a, output logic [15:0] d);
    rb_addr = a;
    #1;
    d = rb_rdata;
  endtask

  task automatic bus_wr(input logic [15:0] a, input logic [15:0] d);
    @(negedge clk);
    rb_wr = 1'b1; rb_addr = a; rb_wdata = d;
    @(posedge clk);
    #1 rb_wr = 1'b0;
  endtask

  // One cycle of access and optional status write, then sample after the edge.
  task automatic cycle(input logic av, input logic [15:0] a, input logic s,
                       input logic d, input logic [5:0] syn, input logic sw);
    @(negedge clk);
    acc_valid = av; acc_addr = a; err_single = s; err_double = d;
    err_syndrome = syn; rb_wr = sw; rb_addr = A_STAT; rb_wdata = 16'h1234;
    @(posedge clk);
    #1;
    acc_valid = 1'b0; err_single = 1'b0; err_double = 1'b0; rb_wr = 1'b0;
  endtask

  initial begin
    logic [15:0] v;
    string r;
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state
    rd(A_STAT, v); chk("R1", "status after reset", v, 16'hFFFF);
    rd(A_CTRL, v); chk("R1", "control after reset", v, 16'h0000);
    chk("R1", "irq after reset", {15'd0, irq_o}, 16'd0);
    chk("R1", "pend after reset", pend_o, PEND);
    @(negedge clk) rst_n = 1'b1;

    // R9: control readback, enable requests
    bus_wr(A_CTRL, 16'h0001);
    rd(A_CTRL, v); chk("R9", "control readback", v, 16'h0001);

    for (int i = 0; i < NV; i++) begin
      r = $sformatf("R%0d", VT[i].req);
      cycle(VT[i].av, VT[i].a, VT[i].s, VT[i].d, VT[i].syn, VT[i].sw);
      chk(r, $sformatf("row %0d irq", i), {15'd0, irq_o}, {15'd0, VT[i].ei});
      chk("R10", $sformatf("row %0d pend", i), pend_o,
          PEND | (VT[i].ei ? 16'h8000 : 16'h0000));
      rd(A_ADDR, v); chk(r, $sformatf("row %0d address", i), v, VT[i].ea);
      rd(A_STAT, v); chk(r, $sformatf("row %0d status", i), v, VT[i].es);
      @(posedge clk); #1;
      chk("R10", $sformatf("row %0d irq gone", i), {15'd0, irq_o}, 16'd0);
    end

    // R9: all bits stored; bit 0 clear blocks the request but not the log
    bus_wr(A_CTRL, 16'hA5A4);
    rd(A_CTRL, v); chk("R9", "control full readback", v, 16'hA5A4);
    cycle(1'b0, 16'h0, 1'b0, 1'b0, 6'h0, 1'b1);
    cycle(1'b1, 16'hBEEF, 1'b1, 1'b0, 6'h2A, 1'b0);
    chk("R9", "irq while disabled", {15'd0, irq_o}, 16'd0);
    chk("R9", "pend while disabled", pend_o, PEND);
    rd(A_STAT, v); chk("R9", "logged while disabled", v, 16'hFF56);
    rd(A_ADDR, v); chk("R3", "address while disabled", v, 16'hBEEF);

    // R12: unmapped address
    rd(16'o177027, v); chk("R12", "unmapped read", v, 16'h0000);
    rd(16'h0000, v);   chk("R12", "zero address read", v, 16'h0000);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule